// File: doc/BRIEF.md
# Serial Port Modem Control and Loopback Router

This block holds the modem control byte of a UART-style serial controller and performs all of the routing that the byte selects. A processor bus writes and reads the byte at a fixed offset from the controller's base. Four low-bits of the byte drive four active-low handshake pins: terminal-ready, request-to-send and two general-purpose auxiliary lines. A fifth bit turns on a self-test mode. In that mode the serial path and the handshake path are both closed inside the chip.

In self-test mode the outgoing serial pin idles at the mark level (1). The transmit shifter's output becomes the receiver's input, and the external receive pin is disregarded. The four handshake pins go inactive. The four incoming handshake lines (clear-to-send, data-set-ready, ring and carrier detect) are then taken from the stored control bits instead of from the pins. A second readable byte reports the four incoming line levels as active-high bits. It also holds four change flags that a read of that byte clears. The baud generator, the shifters, the FIFOs and interrupt logic sit outside this block. It supplies them the serial input they should use.

Top module: `uart_mdm_ctl`

## Requirements
- R1: After reset the control byte is 0x00, all four handshake output pins are 1, self-test is off, and the status byte reads 0x00 when all incoming handshake pins are high (inactive).
- R2: A write at offset 4 stores bits 0..4. A read at offset 4 returns those five bits unchanged, with bits 5..7 always 0.
- R3: With self-test off, each output pin is the inverse of its stored bit: terminal-ready from bit 0, request-to-send from bit 1, auxiliary-1 from bit 2, auxiliary-2 from bit 3.
- R4: With bit 4 set, the outgoing serial pin is 1 whatever the transmit shifter drives. With bit 4 clear, the pin follows the transmit shifter.
- R5: With bit 4 set, the receiver's serial input equals the transmit shifter output and the external receive pin has no effect. With bit 4 clear, it equals the external receive pin.
- R6: With bit 4 set, all four handshake output pins are 1 regardless of bits 0..3.
- R7: With bit 4 set, the incoming handshake pins have no effect. Data-set-ready is taken from bit 0, clear-to-send from bit 1, ring from bit 2 and carrier detect from bit 3, with a set bit reading as asserted.
- R8: The status byte at offset 6 reports active-high levels: clear-to-send in bit 4, data-set-ready in bit 5, ring in bit 6 and carrier detect in bit 7. With self-test off, each level is the inverse of its active-low pin.
- R9: Status bits 0..3 are change flags for the levels in bits 4..7 respectively. A flag sets when its level changes, including a change caused by entering or leaving self-test. Once set, it stays set until the status byte is read.
- R10: A read of the status byte returns the flags as they stood before the read, then clears them.
- R11: A write to any offset other than 4 changes nothing, and a read of any offset other than 4 or 6 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 3 | Register offset within the serial controller |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data, valid the cycle after rd_en |
| tx_shift_out | input | 1 | Serial bit from the transmit shifter |
| rx_serial | output | 1 | Serial bit to feed the receive shifter |
| txd_pin | output | 1 | Outgoing serial pin |
| rxd_pin | input | 1 | Incoming serial pin |
| dtr_n | output | 1 | Terminal-ready pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| aux1_n | output | 1 | Auxiliary output 1, active low |
| aux2_n | output | 1 | Auxiliary output 2, active low |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring pin, active low |
| dcd_n | input | 1 | Carrier-detect pin, active low |

## Verification
The bench drives the external handshake pins to their active levels while self-test is on and expects no trace of them in the status byte. A design that leaked the pins through the multiplexer would report all four levels set. Entering and leaving self-test is checked for the change flags it must raise. A design comparing only pin transitions would miss those flags, and one with a crossed loopback mapping would flag the wrong bits. Back-to-back status reads confirm that the first read returns the flags and the second returns none; a design that cleared before capturing would lose them. Writes with bits 5..7 set and writes at unmapped offsets expose a register that stores too wide or decodes too loosely.

// File: rtl/uart_mdm_pkg.sv
package uart_mdm_pkg;

  // control byte bit positions; the loopback mapping depends on them
  localparam int CB_DTR   = 0;
  localparam int CB_RTS   = 1;
  localparam int CB_AUX1  = 2;
  localparam int CB_AUX2  = 3;
  localparam int CB_LOOP  = 4;
  localparam int CTL_BITS = 5;

  localparam int MDM_LINES = 4;

  // incoming handshake levels, active high; order matches status bits 4..7
  typedef struct packed {
    logic rlsd;
    logic ri;
    logic dsr;
    logic cts;
  } mdm_lvl_t;

endpackage

// File: rtl/mdm_ctl_reg.sv
module mdm_ctl_reg
  import uart_mdm_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 8,
  parameter int CTL_OFS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [CTL_BITS-1:0] ctl_q
);

  localparam logic [ADDR_W-1:0] OFS = ADDR_W'(CTL_OFS);

  logic hit;
  assign hit = wr_en && (addr == OFS);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (hit) begin
      ctl_q <= wdata[CTL_BITS-1:0];
    end
  end

endmodule

// File: rtl/mdm_route.sv
module mdm_route
  import uart_mdm_pkg::*;
(
  input  logic [CTL_BITS-1:0]  ctl_q,
  input  logic                 tx_shift_out,
  input  logic                 rxd_pin,
  input  logic [MDM_LINES-1:0] in_pin_n,
  output logic [MDM_LINES-1:0] out_pin_n,
  output logic                 txd_pin,
  output logic                 rx_serial,
  output mdm_lvl_t             lvl
);

  logic     loop_on;
  mdm_lvl_t loop_lvl;
  mdm_lvl_t ext_lvl;

  assign loop_on = ctl_q[CB_LOOP];

  // one output pin per stored bit; forced inactive in self-test
  for (genvar i = 0; i < MDM_LINES; i++) begin : g_out
    assign out_pin_n[i] = loop_on | ~ctl_q[i];
  end

  assign txd_pin   = loop_on ? 1'b1 : tx_shift_out;
  assign rx_serial = loop_on ? tx_shift_out : rxd_pin;

  // in_pin_n order: [0] cts, [1] dsr, [2] ri, [3] dcd
  assign ext_lvl = mdm_lvl_t'(~in_pin_n);

  always_comb begin
    loop_lvl.dsr  = ctl_q[CB_DTR];
    loop_lvl.cts  = ctl_q[CB_RTS];
    loop_lvl.ri   = ctl_q[CB_AUX1];
    loop_lvl.rlsd = ctl_q[CB_AUX2];
  end

  assign lvl = loop_on ? loop_lvl : ext_lvl;

endmodule

// File: rtl/mdm_status.sv
module mdm_status
  import uart_mdm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  mdm_lvl_t             lvl,
  input  logic                 rd_clr,
  output logic [MDM_LINES-1:0] delta_q
);

  logic [MDM_LINES-1:0] prev_q;
  logic [MDM_LINES-1:0] cur;

  assign cur = lvl;

  always_ff @(posedge clk) begin
    prev_q <= cur;
  end

  // a change in the clearing cycle wins over the clear
  for (genvar i = 0; i < MDM_LINES; i++) begin : g_delta
    always_ff @(posedge clk) begin
      if (rst) begin
        delta_q[i] <= 1'b0;
      end else if (cur[i] != prev_q[i]) begin
        delta_q[i] <= 1'b1;
      end else if (rd_clr) begin
        delta_q[i] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/uart_mdm_ctl.sv
module uart_mdm_ctl
  import uart_mdm_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 8,
  parameter int CTL_OFS = 4,
  parameter int STS_OFS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              tx_shift_out,
  output logic              rx_serial,
  output logic              txd_pin,
  input  logic              rxd_pin,
  output logic              dtr_n,
  output logic              rts_n,
  output logic              aux1_n,
  output logic              aux2_n,
  input  logic              cts_n,
  input  logic              dsr_n,
  input  logic              ri_n,
  input  logic              dcd_n
);

  localparam logic [ADDR_W-1:0] C_OFS = ADDR_W'(CTL_OFS);
  localparam logic [ADDR_W-1:0] S_OFS = ADDR_W'(STS_OFS);

  logic [CTL_BITS-1:0]  ctl_q;
  logic [MDM_LINES-1:0] out_pin_n;
  logic [MDM_LINES-1:0] delta_q;
  mdm_lvl_t             lvl;
  logic                 sts_rd;
  logic [DATA_W-1:0]    rdata_q;

  mdm_ctl_reg #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CTL_OFS(CTL_OFS)
  ) ctl_i (
    .clk  (clk),
    .rst  (rst),
    .wr_en(wr_en),
    .addr (addr),
    .wdata(wdata),
    .ctl_q(ctl_q)
  );

  mdm_route route_i (
    .ctl_q       (ctl_q),
    .tx_shift_out(tx_shift_out),
    .rxd_pin     (rxd_pin),
    .in_pin_n    ({dcd_n, ri_n, dsr_n, cts_n}),
    .out_pin_n   (out_pin_n),
    .txd_pin     (txd_pin),
    .rx_serial   (rx_serial),
    .lvl         (lvl)
  );

  assign sts_rd = rd_en && (addr == S_OFS);

  mdm_status sts_i (
    .clk    (clk),
    .rst    (rst),
    .lvl    (lvl),
    .rd_clr (sts_rd),
    .delta_q(delta_q)
  );

  assign dtr_n  = out_pin_n[CB_DTR];
  assign rts_n  = out_pin_n[CB_RTS];
  assign aux1_n = out_pin_n[CB_AUX1];
  assign aux2_n = out_pin_n[CB_AUX2];

  always_ff @(posedge clk) begin
    if (rst || !rd_en) begin
      rdata_q <= '0;
    end else if (addr == C_OFS) begin
      rdata_q <= DATA_W'(ctl_q);
    end else if (addr == S_OFS) begin
      rdata_q <= DATA_W'({lvl, delta_q});
    end else begin
      rdata_q <= '0;
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/uart_mdm_ctl_chk.sv
module uart_mdm_ctl_chk #(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 8,
  parameter int CTL_OFS = 4,
  parameter int STS_OFS = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              tx_shift_out,
  input logic              rx_serial,
  input logic              txd_pin,
  input logic              dtr_n,
  input logic              rts_n,
  input logic              aux1_n,
  input logic              aux2_n,
  input logic              loop_on
);

  localparam logic [ADDR_W-1:0] C_OFS = ADDR_W'(CTL_OFS);
  localparam logic [ADDR_W-1:0] S_OFS = ADDR_W'(STS_OFS);

  // R3
  pol_after_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == C_OFS && !wdata[4]) |=>
      ({aux2_n, aux1_n, rts_n, dtr_n} == ~$past(wdata[3:0])));

  // R6
  loop_pins_idle_chk: assert property (@(posedge clk) disable iff (rst)
    loop_on |-> ({aux2_n, aux1_n, rts_n, dtr_n} == 4'hF));

  // R4
  loop_txd_mark_chk: assert property (@(posedge clk) disable iff (rst)
    loop_on |-> txd_pin);

  // R4
  norm_txd_pass_chk: assert property (@(posedge clk) disable iff (rst)
    !loop_on |-> (txd_pin == tx_shift_out));

  // R5
  loop_rx_feed_chk: assert property (@(posedge clk) disable iff (rst)
    loop_on |-> (rx_serial == tx_shift_out));

  // R2
  ctl_hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == C_OFS) |=> (rdata[7:5] == 3'b000));

  // R11
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr != C_OFS && addr != S_OFS) |=> (rdata == '0));

endmodule

bind uart_mdm_ctl uart_mdm_ctl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .CTL_OFS(CTL_OFS),
  .STS_OFS(STS_OFS)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .addr        (addr),
  .wdata       (wdata),
  .rdata       (rdata),
  .tx_shift_out(tx_shift_out),
  .rx_serial   (rx_serial),
  .txd_pin     (txd_pin),
  .dtr_n       (dtr_n),
  .rts_n       (rts_n),
  .aux1_n      (aux1_n),
  .aux2_n      (aux2_n),
  .loop_on     (ctl_q[uart_mdm_pkg::CB_LOOP])
);

// File: tb/uart_mdm_ctl_tb.sv
module uart_mdm_ctl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] CTL = 3'd4;
  localparam logic [2:0] STS = 3'd6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tx_shift_out = 1'b1;
  logic       rx_serial;
  logic       txd_pin;
  logic       rxd_pin = 1'b1;
  logic       dtr_n, rts_n, aux1_n, aux2_n;
  logic       cts_n = 1'b1;
  logic       dsr_n = 1'b1;
  logic       ri_n  = 1'b1;
  logic       dcd_n = 1'b1;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_mdm_ctl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tx_shift_out(tx_shift_out),
    .rx_serial(rx_serial), .txd_pin(txd_pin), .rxd_pin(rxd_pin),
    .dtr_n(dtr_n), .rts_n(rts_n), .aux1_n(aux1_n), .aux2_n(aux2_n),
    .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic set_pins(input logic [3:0] v_n);  // {dcd,ri,dsr,cts}
    @(negedge clk);
    {dcd_n, ri_n, dsr_n, cts_n} = v_n;
    @(negedge clk);
  endtask

  function automatic logic [7:0] outs();
    return {4'h0, aux2_n, aux1_n, rts_n, dtr_n};
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 outputs after reset", outs(), 8'h0F);
    chk("R1 txd follows shifter", {7'd0, txd_pin}, 8'h01);
    bus_rd(CTL, d);
    chk("R1 control byte", d, 8'h00);
    bus_rd(STS, d);
    chk("R1 status byte", d, 8'h00);
  endtask

  task automatic t_ctl_rw();
    logic [7:0] d;
    bus_wr(CTL, 8'hFF);
    bus_rd(CTL, d);
    chk("R2 upper bits read zero", d, 8'h1F);
    bus_wr(CTL, 8'hA5);
    bus_rd(CTL, d);
    chk("R2 low bits as written", d, 8'h05);
    bus_wr(CTL, 8'h00);
  endtask

  task automatic t_polarity();
    bus_wr(CTL, 8'h05);
    chk("R3 pins inverted 0x05", outs(), 8'h0A);
    bus_wr(CTL, 8'h0A);
    chk("R3 pins inverted 0x0A", outs(), 8'h05);
    bus_wr(CTL, 8'h00);
    chk("R3 pins idle", outs(), 8'h0F);
  endtask

  task automatic t_serial();
    @(negedge clk); tx_shift_out = 1'b0; rxd_pin = 1'b1; #1;
    chk("R4 txd normal", {7'd0, txd_pin}, 8'h00);
    chk("R5 rx normal", {7'd0, rx_serial}, 8'h01);
    bus_wr(CTL, 8'h1F);
    chk("R6 pins idle in loop", outs(), 8'h0F);
    chk("R4 txd marks in loop", {7'd0, txd_pin}, 8'h01);
    chk("R5 rx from shifter 0", {7'd0, rx_serial}, 8'h00);
    @(negedge clk); tx_shift_out = 1'b1; rxd_pin = 1'b0; #1;
    chk("R5 rx from shifter 1", {7'd0, rx_serial}, 8'h01);
    bus_wr(CTL, 8'h00);
    chk("R5 rx back to pin", {7'd0, rx_serial}, 8'h00);
    @(negedge clk); rxd_pin = 1'b1;
  endtask

  task automatic t_status_delta();
    logic [7:0] d;
    bus_rd(STS, d);
    set_pins(4'b1110);  // cts active
    bus_rd(STS, d);
    chk("R8 R9 cts level and flag", d, 8'h11);
    bus_rd(STS, d);
    chk("R10 flag cleared by read", d, 8'h10);
    set_pins(4'b0101);  // cts released, dsr + dcd active
    bus_rd(STS, d);
    chk("R9 three flags", d, 8'hAB);
    set_pins(4'b1111);
    bus_rd(STS, d);
    chk("R9 release flags", d, 8'h0A);
    bus_rd(STS, d);
    chk("R10 quiet after read", d, 8'h00);
  endtask

  task automatic t_loop_modem();
    logic [7:0] d;
    bus_wr(CTL, 8'h15);
    set_pins(4'b0000);  // all external active, must be ignored
    bus_rd(STS, d);
    chk("R7 dsr ri from dtr aux1", d, 8'h66);
    bus_rd(STS, d);
    chk("R7 external pins ignored", d, 8'h60);
    bus_wr(CTL, 8'h1A);
    bus_rd(STS, d);
    chk("R7 cts rlsd from rts aux2", d, 8'h9F);
    bus_wr(CTL, 8'h00);
    bus_rd(STS, d);
    chk("R9 flags on leaving loop", d, 8'hF6);
    set_pins(4'b1111);
    bus_rd(STS, d);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    bus_wr(CTL, 8'h03);
    bus_wr(3'd5, 8'hFF);
    bus_wr(3'd0, 8'h1C);
    bus_rd(CTL, d);
    chk("R11 stray writes ignored", d, 8'h03);
    chk("R11 pins unchanged", outs(), 8'h0C);
    bus_rd(3'd5, d);
    chk("R11 unmapped read zero", d, 8'h00);
    bus_wr(CTL, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_ctl_rw();
    t_polarity();
    t_serial();
    t_status_delta();
    t_loop_modem();
    t_unmapped();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule